// File: doc/BRIEF.md
# Interval Timer Rate-Generator Channel

This block is one channel of a byte-programmed interval timer. Software reaches it through a single 8-bit write port. A strobe steers each byte either to the control register or to the count register. A control byte names a channel and describes how that channel is to be programmed. When the byte names this channel and asks for byte-pair loading, rate-generator operation and binary counting, the channel arms itself. Two data bytes then follow: the low half of the count first, then the high half. When the high byte arrives the channel starts to count down. From then on it drives one low clock on its output once per period, and the period equals the loaded count.

The channel is built around a loader state machine with four states. `ST_IDLE` means the channel is unprogrammed or was given a setup it does not support. `ST_WAIT_LO` is armed and expecting the low byte. `ST_WAIT_HI` holds the low byte and expects the high byte. `ST_RUN` is counting. The transitions are named as follows. `arm` moves from any state to `ST_WAIT_LO` on a supported control byte for this channel. `reject` moves from any state to `ST_IDLE` on an unsupported control byte for this channel. `take_lo` moves from `ST_WAIT_LO` to `ST_WAIT_HI` on a data byte. `launch` moves from `ST_WAIT_HI` to `ST_RUN` on a data byte. While in `ST_RUN`, data bytes refill the stored count in pairs. A new count takes effect only at the next reload, so the period in progress is never restarted. A stored value of zero stands for the full 65536-clock period.

Top module: `pit_channel`

## Requirements
- R1: After reset the loader is in `ST_IDLE` and `rate_out` is 1. Data-port writes made before any control byte leave `rate_out` at 1.
- R2: A control byte is read as follows. Bits 7:6 are the channel number and must equal `CHAN_ID`. Bits 5:4 are the access order and must be 2'b11, meaning low byte then high byte. Bits 3:1 are the mode and must be 3'b010, the rate generator. Bit 0 selects BCD and must be 0. With `CHAN_ID` = 0 the byte 0x34 arms the channel.
- R3: After arming, the first data byte is the low half of the count and the second is the high half. If the high byte is captured at clock edge E with count N, `rate_out` is first 0 in the cycle that follows edge E+N-1.
- R4: While running, `rate_out` is 0 for exactly one clock in every N clocks and is 1 otherwise. The counter reloads the stored count by itself after each pulse.
- R5: A stored count of 0 gives a period of 65536 clocks.
- R6: A count pair written while running does not disturb the current period. The counter uses the new count for the first reload that follows the capture of its high byte.
- R7: A control byte addressed to this channel stops the output at once: `rate_out` is 1 from the next cycle on. No pulse appears until a full low-then-high pair has been written.
- R8: A control byte whose channel field differs from `CHAN_ID` has no effect. A running channel keeps its pulse timing.
- R9: A control byte for this channel with an unsupported access order, mode or BCD setting returns the channel to `ST_IDLE`, and later data bytes produce no pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counting advances one step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| sel_ctrl | input | 1 | 1 steers the write to the control register, 0 to the count register |
| wr_data | input | 8 | Write data byte |
| rate_out | output | 1 | Rate output, high at rest and low for one clock per period |

## Verification
Several properties are checked on every cycle. The output never stays low for two clocks while the stored count exceeds one. The running counter steps down by exactly one between reloads and stays within 1 to 65536. A control byte for this channel silences the output on the next cycle. A foreign control byte leaves the loader state untouched. Launch starts the counter. Data bytes in the idle state start nothing. Only the bench scenarios can show the absolute pulse positions: the first pulse at N-1 clocks after launch, a new count held back until the next reload, the full 65536-clock period for a zero count, and the silence after an unsupported setup. The bench shows these by matching every observed low cycle against a queue of predicted cycle numbers.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_LO = 2'd1,
        ST_WAIT_HI = 2'd2,
        ST_RUN     = 2'd3
    } ld_state_e;

    typedef struct packed {
        logic [1:0] chan;
        logic [1:0] access;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    localparam logic [1:0] ACCESS_LO_HI = 2'b11;
    localparam logic [2:0] MODE_RATE    = 3'b010;

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic       wr_en,
    input  logic       sel_ctrl,
    input  logic [7:0] wr_data,
    output logic       cw_hit,
    output logic       cw_ok,
    output logic       data_wr
);

    ctrl_word_t cw;

    always_comb begin
        cw      = ctrl_word_t'(wr_data);
        cw_hit  = wr_en && sel_ctrl && (cw.chan == CHAN_ID);
        cw_ok   = (cw.access == ACCESS_LO_HI) && (cw.mode == MODE_RATE) && !cw.bcd;
        data_wr = wr_en && !sel_ctrl;
    end

endmodule

// File: rtl/pit_load_fsm.sv
module pit_load_fsm
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_hit,
    input  logic              cw_ok,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wr_byte,
    output ld_state_e         state,
    output logic              running,
    output logic              start,
    output logic [CNT_W-1:0]  start_val,
    output logic [CNT_W-1:0]  reload_val
);

    ld_state_e         state_q, state_n;
    logic [BYTE_W-1:0] lo_q;
    logic              hi_next_q;
    logic [CNT_W-1:0]  reload_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next-state logic: arm, reject, take_lo, launch
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    state_n = ST_IDLE;
            ST_WAIT_LO: if (data_wr) state_n = ST_WAIT_HI;
            ST_WAIT_HI: if (data_wr) state_n = ST_RUN;
            ST_RUN:     state_n = ST_RUN;
        endcase
        if (cw_hit) state_n = cw_ok ? ST_WAIT_LO : ST_IDLE;
    end

    // byte staging and stored count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q      <= '0;
            hi_next_q <= 1'b0;
            reload_q  <= '0;
        end else if (cw_hit) begin
            hi_next_q <= 1'b0;
        end else if (data_wr) begin
            unique case (state_q)
                ST_IDLE:    ;
                ST_WAIT_LO: lo_q <= wr_byte;
                ST_WAIT_HI: begin
                    reload_q  <= {wr_byte, lo_q};
                    hi_next_q <= 1'b0;
                end
                ST_RUN: begin
                    if (!hi_next_q) begin
                        lo_q      <= wr_byte;
                        hi_next_q <= 1'b1;
                    end else begin
                        reload_q  <= {wr_byte, lo_q};
                        hi_next_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        state      = state_q;
        running    = (state_q == ST_RUN);
        start      = (state_q == ST_WAIT_HI) && data_wr && !cw_hit;
        start_val  = {wr_byte, lo_q};
        reload_val = reload_q;
    end

endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             start,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W:0]   cnt,
    output logic             rate_out
);

    localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

    logic [CNT_W:0] cnt_q;

    // zero stands for the full 2**CNT_W period
    function automatic logic [CNT_W:0] expand(input logic [CNT_W-1:0] v);
        return {(v == '0), v};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= expand(start_val);
        else if (!running)       cnt_q <= '0;
        else if (cnt_q == ONE)   cnt_q <= expand(reload_val);
        else                     cnt_q <= cnt_q - ONE;
    end

    always_comb begin
        cnt      = cnt_q;
        rate_out = !(running && (cnt_q == ONE));
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0,
    parameter int         BYTE_W  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       sel_ctrl,
    input  logic [7:0] wr_data,
    output logic       rate_out
);

    localparam int CNT_W = 2 * BYTE_W;

    logic             cw_hit, cw_ok, data_wr;
    ld_state_e        fsm_state;
    logic             running, start;
    logic [CNT_W-1:0] start_val, reload_val;
    logic [CNT_W:0]   cnt;

    pit_ctrl_decode #(.CHAN_ID(CHAN_ID)) u_dec (
        .wr_en    (wr_en),
        .sel_ctrl (sel_ctrl),
        .wr_data  (wr_data),
        .cw_hit   (cw_hit),
        .cw_ok    (cw_ok),
        .data_wr  (data_wr)
    );

    pit_load_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cw_hit     (cw_hit),
        .cw_ok      (cw_ok),
        .data_wr    (data_wr),
        .wr_byte    (wr_data[BYTE_W-1:0]),
        .state      (fsm_state),
        .running    (running),
        .start      (start),
        .start_val  (start_val),
        .reload_val (reload_val)
    );

    pit_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .start      (start),
        .start_val  (start_val),
        .reload_val (reload_val),
        .cnt        (cnt),
        .rate_out   (rate_out)
    );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0,
    parameter int         BYTE_W  = 8,
    localparam int        CNT_W   = 2 * BYTE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             sel_ctrl,
    input logic [7:0]       wr_data,
    input logic             rate_out,
    input ld_state_e        fsm_state,
    input logic             running,
    input logic [CNT_W:0]   cnt,
    input logic [CNT_W-1:0] reload_val
);

    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;
    localparam logic [CNT_W:0] ONE  = (CNT_W+1)'(1);

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_out && reload_val != CNT_W'(1)) |=> rate_out);

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && $past(cnt) > ONE) |-> (cnt == $past(cnt) - ONE));

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt != '0 && cnt <= FULL));

    p_cw_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ctrl && wr_data[7:6] == CHAN_ID) |=> (rate_out && !running));

    p_foreign_cw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ctrl && wr_data[7:6] != CHAN_ID) |=> (fsm_state == $past(fsm_state)));

    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_WAIT_HI && wr_en && !sel_ctrl) |=> running);

    p_idle_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && wr_en && !sel_ctrl) |=> (!running && rate_out));

endmodule

bind pit_channel pit_channel_chk #(.CHAN_ID(CHAN_ID), .BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .sel_ctrl   (sel_ctrl),
    .wr_data    (wr_data),
    .rate_out   (rate_out),
    .fsm_state  (fsm_state),
    .running    (running),
    .cnt        (cnt),
    .reload_val (reload_val)
);

// File: tb/sim_pit_channel.sv
module sim_pit_channel;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       sel_ctrl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rate_out;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;

    int    exp_cyc[$];
    string exp_tag[$];

    pit_channel u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel_ctrl (sel_ctrl),
        .wr_data  (wr_data),
        .rate_out (rate_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_pulse(input int c, input string tag);
        exp_cyc.push_back(c);
        exp_tag.push_back(tag);
    endtask

    // drive one write so that it is captured on the edge that makes cyc == target
    task automatic wr_at(input int target, input bit ctrl, input logic [7:0] d);
        while (cyc < target - 1) @(negedge clk);
        wr_en = 1'b1; sel_ctrl = ctrl; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; sel_ctrl = 1'b0;
    endtask

    task automatic run_to(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // monitor: every low cycle must match the head of the expectation queue
    always @(negedge clk) begin
        if (rst_n && rate_out === 1'b0) begin
            if (exp_cyc.size() == 0) begin
                check(1'b0, "R7/R8/R9 unexpected pulse", cyc, -1);
            end else begin
                int    c;
                string t;
                c = exp_cyc.pop_front();
                t = exp_tag.pop_front();
                check(c == cyc, t, cyc, c);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual %0d expected <%0d", cyc, WATCHDOG);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rate_out === 1'b1, "R1 reset output", int'(rate_out), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: data bytes before any control byte are ignored
        wr_at(10, 1'b0, 8'h05);
        wr_at(11, 1'b0, 8'h00);
        run_to(40);
        check(rate_out === 1'b1, "R1 idle data ignored", int'(rate_out), 1);

        // R2/R3/R4: 0x34 then count 5
        wr_at(50, 1'b1, 8'h34);
        wr_at(51, 1'b0, 8'h05);
        wr_at(52, 1'b0, 8'h00);
        expect_pulse(56, "R3 first pulse N=5");
        expect_pulse(61, "R4 period 5");
        expect_pulse(66, "R4 period 5");
        // R6: new count 8 mid-run, current period kept
        wr_at(68, 1'b0, 8'h08);
        wr_at(69, 1'b0, 8'h00);
        expect_pulse(71, "R6 current period unaffected");
        expect_pulse(79, "R6 new count at reload");
        expect_pulse(87, "R6 period 8");
        // R8: control byte for channel 1 ignored
        wr_at(90, 1'b1, 8'h74);
        expect_pulse(95, "R8 foreign control ignored");
        expect_pulse(103, "R8 foreign control ignored");
        expect_pulse(111, "R8 foreign control ignored");
        // R7: control byte stops output until a full pair
        wr_at(113, 1'b1, 8'h34);
        wr_at(115, 1'b0, 8'h03);
        run_to(125);
        check(rate_out === 1'b1, "R7 half-loaded stays high", int'(rate_out), 1);
        wr_at(130, 1'b0, 8'h00);
        expect_pulse(132, "R7 restart after full pair");
        expect_pulse(135, "R4 period 3");
        expect_pulse(138, "R4 period 3");
        // R9: unsupported mode (square wave) to this channel -> idle
        wr_at(140, 1'b1, 8'h36);
        wr_at(142, 1'b0, 8'h02);
        wr_at(143, 1'b0, 8'h00);
        run_to(200);
        check(rate_out === 1'b1, "R9 unsupported setup idle", int'(rate_out), 1);
        check(exp_cyc.size() == 0, "R9 queue drained", exp_cyc.size(), 0);
        // R2/R3: high byte matters, count 0x012C = 300
        wr_at(210, 1'b1, 8'h34);
        wr_at(211, 1'b0, 8'h2C);
        wr_at(212, 1'b0, 8'h01);
        expect_pulse(511, "R3 two-byte count 300");
        expect_pulse(811, "R4 period 300");
        // R5: count 0 means 65536
        wr_at(900, 1'b1, 8'h34);
        wr_at(901, 1'b0, 8'h00);
        wr_at(902, 1'b0, 8'h00);
        expect_pulse(66437, "R5 zero count first pulse");
        expect_pulse(131973, "R5 period 65536");
        run_to(132000);
        check(exp_cyc.size() == 0, "R5 all pulses seen", exp_cyc.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule